// File: doc/BRIEF.md
# Configurable GPIO Port Register Bank

This block holds the register state and pin logic for a byte-wide bidirectional I/O port inside a serial-bus port expander. A protocol engine, which is not part of this block, reaches it through a small register port. That port carries a 2-bit index, a write strobe with data, and a read strobe that loads a registered read-data byte. On the pin side the block takes the raw pin levels and returns, for each pin, an output level and an output enable.

Four registers sit behind the index: a read-only view of the pins, the output levels, a per-bit polarity inversion that acts only on the pin view, and a per-bit direction. Bit 0 is an open-drain pin. It can pull low, but it never drives high.

A two-state sequencer controls the block. After reset it waits in `ST_PRIME` while the pin synchroniser fills. During that time no pin is driven and the strobes are ignored. Transition `PRIME_DONE` moves it to `ST_RUN` after `SYNC_STAGES` clocks. Only reset leaves `ST_RUN`, and it returns the block to `ST_PRIME`.

Top module: `gpx_port_bank`

## Requirements
- R1: Register index encoding: 0 = pin view, 1 = output levels, 2 = polarity, 3 = direction. After reset, reads return 0x00 from index 1, 0xF0 from index 2 and 0xFF from index 3, and `pin_oe` is 0x00.
- R2: While reset is held, and for `SYNC_STAGES` (2) clocks after it is released, `pin_oe` is 0x00. Any write or read strobe seen in those clocks is ignored.
- R3: A read of index 0 returns the synchronised pin levels XOR the polarity register. The direction of each pin does not affect this value. A write to index 0 changes no register.
- R4: A read of index 1 returns the stored output levels, not the pin levels.
- R5: For a push-pull bit (bits 7..1), direction bit 1 gives `pin_oe`=0 and `pin_out`=0. Direction bit 0 gives `pin_oe`=1 and `pin_out` equal to the output-level bit.
- R6: Bit 0 never drives high: `pin_out[0]` is always 0. `pin_oe[0]` is 1 only when direction bit 0 is 0 and output-level bit 0 is 0.
- R7: A write reaches `pin_oe` and `pin_out` right after the clock edge that takes the strobe. When a bit switches to output, it drives the output level that was already stored.
- R8: `rd_data` changes only on an edge where `rd_en` is accepted, so the sampled pin view holds between reads even if the pins change.
- R9: When a read and a write hit the same index on one edge, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 2 | Register index for both strobes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bench sweeps every direction value against two output patterns, with one pattern driving bit 0 high and the other low. A design that drove bit 0 high, or that let an input pin leak its output level, fails there. It also sweeps every polarity value and every pin pattern through the pin view, which catches inversion applied to the wrong register or to the outputs. Targeted cases cover strobes during priming, a read that collides with a write, a write to the read-only index, and pins that change between reads. A design that took early strobes, returned the new value on a collision, or resampled pins without a strobe would show a changed byte at the ports.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        IDX_PINS   = 2'd0,
        IDX_LEVEL  = 2'd1,
        IDX_INVERT = 2'd2,
        IDX_DIR    = 2'd3
    } gpx_idx_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } gpx_state_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_pin_drive.sv
module gpx_pin_drive #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] OD_MASK = 8'h01
) (
    input  logic             en,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] drv
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (OD_MASK[i]) begin : g_open_drain
            // pull low only; a stored 1 releases the pin
            assign oe[i]  = en & ~dir[i] & ~level[i];
            assign drv[i] = 1'b0;
        end else begin : g_push_pull
            assign oe[i]  = en & ~dir[i];
            assign drv[i] = en & ~dir[i] & level[i];
        end
    end
endmodule

// File: rtl/gpx_port_bank.sv
module gpx_port_bank
    import gpx_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] LEVEL_RST   = 8'h00,
    parameter logic [WIDTH-1:0] INVERT_RST  = 8'hF0,
    parameter logic [WIDTH-1:0] DIR_RST     = 8'hFF,
    parameter logic [WIDTH-1:0] OD_MASK     = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_idx,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    localparam int CW = (SYNC_STAGES > 1) ? $clog2(SYNC_STAGES) : 1;
    localparam logic [CW-1:0] PRIME_LAST = CW'(SYNC_STAGES - 1);

    gpx_state_e       state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             run;
    gpx_idx_e         idx;
    logic [WIDTH-1:0] level_q, invert_q, dir_q;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] rd_mux;

    assign idx = gpx_idx_e'(reg_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: PRIME_DONE after SYNC_STAGES clocks
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_PRIME: begin
                if (cnt_q == PRIME_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        unique case (state_q)
            ST_PRIME: run = 1'b0;
            ST_RUN:   run = 1'b1;
        endcase
    end

    gpx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= LEVEL_RST;
            invert_q <= INVERT_RST;
            dir_q    <= DIR_RST;
        end else if (run && wr_en) begin
            unique case (idx)
                IDX_PINS:   ;
                IDX_LEVEL:  level_q  <= wr_data;
                IDX_INVERT: invert_q <= wr_data;
                IDX_DIR:    dir_q    <= wr_data;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_PINS:   rd_mux = pins_sync ^ invert_q;
            IDX_LEVEL:  rd_mux = level_q;
            IDX_INVERT: rd_mux = invert_q;
            IDX_DIR:    rd_mux = dir_q;
        endcase
    end

    // read register doubles as the input snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (run && rd_en) begin
            rd_data <= rd_mux;
        end
    end

    gpx_pin_drive #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_drive (
        .en    (run),
        .dir   (dir_q),
        .level (level_q),
        .oe    (pin_oe),
        .drv   (pin_out)
    );
endmodule

// File: rtl/gpx_port_bank_chk.sv
module gpx_port_bank_chk #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] OD_MASK = 8'h01
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [1:0]       reg_idx,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe
);
    AST_NO_OE_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pin_oe == '0); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && rd_en) |=> $stable(rd_data)); // R8

    AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe & ~OD_MASK) == '0); // R5

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        run && wr_en && reg_idx == 2'd3 |=>
        (pin_oe & ~OD_MASK) == (~$past(wr_data) & ~OD_MASK)); // R7

    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        run && wr_en && reg_idx == 2'd1 |=>
        (pin_oe & OD_MASK & $past(wr_data)) == '0); // R6
endmodule

bind gpx_port_bank gpx_port_bank_chk #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .reg_idx (reg_idx),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpx_port_bank_tb.sv
module gpx_port_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_idx = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpx_port_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_oe(logic [7:0] dir, logic [7:0] lvl);
        return ~dir & ~(lvl & 8'h01);
    endfunction

    function automatic logic [7:0] exp_out(logic [7:0] dir, logic [7:0] lvl);
        return lvl & ~dir & 8'hFE;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] i, logic [7:0] d);
        @(negedge clk);
        reg_idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] i, output logic [7:0] d);
        @(negedge clk);
        reg_idx = i; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_pins(logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        chk("R2 oe in reset", pin_oe, 8'h00);
        // release and strobe during priming
        rst_n = 1'b1; reg_idx = 2'd3; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; reg_idx = 2'd2; rd_en = 1'b1;
        chk("R2 oe priming", pin_oe, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2 read ignored", rd_data, 8'h00);
        repeat (3) @(negedge clk);
        chk("R2 oe after prime", pin_oe, 8'h00);
        rd(2'd1, v); chk("R1 level reset", v, 8'h00);
        rd(2'd2, v); chk("R1 invert reset", v, 8'hF0);
        rd(2'd3, v); chk("R1 dir reset (R2 write dropped)", v, 8'hFF);
        chk("R1 oe reset", pin_oe, 8'h00);

        // R3: pin view, writes to index 0 ignored
        set_pins(8'h5C);
        rd(2'd0, v); chk("R3 pin view", v, 8'h5C ^ 8'hF0);
        wr(2'd0, 8'hA7);
        rd(2'd1, v); chk("R3 idx0 write level", v, 8'h00);
        rd(2'd2, v); chk("R3 idx0 write invert", v, 8'hF0);
        rd(2'd3, v); chk("R3 idx0 write dir", v, 8'hFF);
        rd(2'd0, v); chk("R3 idx0 write view", v, 8'h5C ^ 8'hF0);

        // R4: level readback is stored value
        wr(2'd1, 8'hA5);
        set_pins(8'h00);
        rd(2'd1, v); chk("R4 level readback", v, 8'hA5);
        chk("R5 inputs undriven", pin_oe, 8'h00);
        chk("R5 inputs out zero", pin_out, 8'h00);

        // R7: switching to output drives held level, right after edge
        wr(2'd1, 8'h3C);
        chk("R7 oe still off", pin_oe, 8'h00);
        @(negedge clk);
        reg_idx = 2'd3; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 oe next clock", pin_oe, exp_oe(8'h00, 8'h3C));
        chk("R7 out next clock", pin_out, exp_out(8'h00, 8'h3C));
        // R3 direction independence: driven pins still read back through view
        wr(2'd2, 8'h00);
        set_pins(8'h96);
        rd(2'd0, v); chk("R3 view with outputs", v, 8'h96);

        // R9: collision returns old value
        @(negedge clk);
        reg_idx = 2'd1; wr_data = 8'h81; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 collision old", rd_data, 8'h3C);
        rd(2'd1, v); chk("R9 collision new", v, 8'h81);

        // R8: pin view holds without strobe
        rd(2'd0, v);
        set_pins(8'h11);
        chk("R8 hold", rd_data, 8'h96);
        rd(2'd0, v); chk("R8 resample", v, 8'h11);

        // R5/R6: sweep direction against two level patterns
        for (int pat = 0; pat < 2; pat++) begin
            logic [7:0] lvl;
            lvl = (pat == 0) ? 8'h96 : 8'h69;
            wr(2'd1, lvl);
            for (int c = 0; c < 256; c++) begin
                wr(2'd3, 8'(c));
                chk("R5 R6 oe sweep", pin_oe, exp_oe(8'(c), lvl));
                chk("R5 R6 out sweep", pin_out, exp_out(8'(c), lvl));
            end
        end

        // R3: polarity sweep
        set_pins(8'hC3);
        for (int p = 0; p < 256; p++) begin
            wr(2'd2, 8'(p));
            rd(2'd0, v);
            chk("R3 polarity sweep", v, 8'hC3 ^ 8'(p));
        end
        // R3: pin sweep with fixed polarity
        wr(2'd2, 8'h0F);
        for (int q = 0; q < 256; q++) begin
            set_pins(8'(q));
            rd(2'd0, v);
            chk("R3 pin sweep", v, 8'(q) ^ 8'h0F);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule